// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block turns a free-running input clock into an instruction cycle of four input clocks, marked by four mutually exclusive phase strobes. Around those phases it runs a two-stage pipeline. While one instruction executes from the instruction register, the next one is fetched from program memory at the address held in the program counter. The fetched word is taken in on the last phase of the cycle and starts executing on the first phase of the next one, so a straight-line instruction effectively costs one cycle.

The execute unit outside the block receives the current instruction word and two phase-aligned strobes: one for reading operands and one for writing results. When the execute unit asks for a jump, it gives a target address. The block then reloads the program counter and throws away the word it had already prefetched. That slot executes as a forced no-op, flagged on an output, so a taken branch costs exactly two cycles. A divided-by-four clock output can be enabled to mark the cycle rate.

Top module: `qps_sequencer`

## Requirements
- R1: `phase_strobe` is one-hot at all times. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4, and the active bit advances Q1→Q2→Q3→Q4→Q1 on every input clock.
- R2: A synchronous active-high `rst` makes the outputs show Q1, `imem_addr` = 0, `exec_instr` = `NOP_WORD` (default 0) and `exec_nop` = 1 in the cycle that follows.
- R3: `imem_addr` holds steady through a whole instruction cycle. It changes only at the Q4→Q1 boundary, where it becomes the old value plus one when no branch is taken. The increment wraps from 8191 to 0 with the default 13-bit width.
- R4: The `imem_data` word present during Q4 becomes `exec_instr` for all four phases of the next cycle, with `exec_nop` = 0, unless a branch is taken at that Q4.
- R5: `rd_strobe` is high only in Q2 and `wr_strobe` only in Q4, and both stay low for the whole of a cycle in which `exec_nop` = 1.
- R6: A `br_req` seen in Q4 while `exec_nop` = 0 is taken. In the next cycle `imem_addr` = the `br_target` sampled at that Q4, `exec_instr` = `NOP_WORD` and `exec_nop` = 1. The cycle after that executes the word read from the target address.
- R7: A `br_req` in Q1, Q2 or Q3, or in any phase of a forced no-op cycle, has no effect on `imem_addr`, `exec_instr` or `exec_nop`.
- R8: With `rc_mode` = 1, `clkout` is high in Q1 and Q2 and low in Q3 and Q4. With `rc_mode` = 0, `clkout` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_mode | input | 1 | Enables the divided clock output |
| imem_data | input | IW (14) | Word returned by program memory |
| br_req | input | 1 | Branch request from the execute unit |
| br_target | input | PC_W (13) | Branch target address |
| phase_strobe | output | 4 | One-hot phase strobes Q1..Q4 |
| clkout | output | 1 | Input clock divided by four |
| imem_addr | output | PC_W (13) | Program counter / fetch address |
| exec_instr | output | IW (14) | Instruction in the execute slot |
| exec_nop | output | 1 | Execute slot holds a forced no-op |
| rd_strobe | output | 1 | Operand read strobe (Q2) |
| wr_strobe | output | 1 | Destination write strobe (Q4) |

## Verification
Two events can land on the same Q4→Q1 boundary: a branch request and the cycle that is already a forced no-op. Back-to-back and held branch requests make the second request fall inside the flushed slot, and the bench expects it to be ignored. A branch can also coincide with the program counter wrapping. A directed jump to the last address checks that the following plain increment returns to zero, and random targets near the top of the space mix the two. Random requests in every phase are scored against a cycle model in the bench, which is built from the phase rules alone.

// File: rtl/qps_pkg.sv
package qps_pkg;

    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

endpackage

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rc_mode,
    output logic [NUM_PHASES-1:0] strobe,
    output logic                  cycle_last,
    output logic                  clkout
);

    typedef struct packed {
        phase_e ph;
    } ph_state_t;

    ph_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_Q1:   st_d.ph = PH_Q2;
            PH_Q2:   st_d.ph = PH_Q3;
            PH_Q3:   st_d.ph = PH_Q4;
            default: st_d.ph = PH_Q1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph <= PH_Q1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_strobe
        assign strobe[g] = (st_q.ph == phase_e'(g));
    end

    assign cycle_last = (st_q.ph == PH_Q4);
    // divide-by-four square wave: high for the first half of the cycle
    assign clkout     = rc_mode && ((st_q.ph == PH_Q1) || (st_q.ph == PH_Q2));

endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit #(
    parameter int PC_W = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            load,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            if (load) begin
                st_d.pc = target;
            end else begin
                st_d.pc = st_q.pc + 1'b1;   // natural wrap at PC_W bits
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;

endmodule

// File: rtl/qps_ir_stage.sv
module qps_ir_stage #(
    parameter int           IW       = 14,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          flush,
    input  logic [IW-1:0] fetch_word,
    output logic [IW-1:0] instr,
    output logic          forced_nop
);

    typedef struct packed {
        logic [IW-1:0] ir;
        logic          nop;
    } ir_state_t;

    ir_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            if (flush) begin
                st_d.ir  = NOP_WORD;
                st_d.nop = 1'b1;
            end else begin
                st_d.ir  = fetch_word;
                st_d.nop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ir  <= NOP_WORD;
            st_q.nop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr      = st_q.ir;
    assign forced_nop = st_q.nop;

endmodule

// File: rtl/qps_sequencer.sv
module qps_sequencer
    import qps_pkg::*;
#(
    parameter int            PC_W     = 13,
    parameter int            IW       = 14,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rc_mode,
    input  logic [IW-1:0]         imem_data,
    input  logic                  br_req,
    input  logic [PC_W-1:0]       br_target,
    output logic [NUM_PHASES-1:0] phase_strobe,
    output logic                  clkout,
    output logic [PC_W-1:0]       imem_addr,
    output logic [IW-1:0]         exec_instr,
    output logic                  exec_nop,
    output logic                  rd_strobe,
    output logic                  wr_strobe
);

    localparam int RD_PHASE = 1;
    localparam int WR_PHASE = NUM_PHASES - 1;

    logic cycle_last;
    logic take_branch;

    qps_phase_gen u_phase (
        .clk        (clk),
        .rst        (rst),
        .rc_mode    (rc_mode),
        .strobe     (phase_strobe),
        .cycle_last (cycle_last),
        .clkout     (clkout)
    );

    // a forced no-op cannot itself redirect the fetch stream
    assign take_branch = cycle_last && br_req && !exec_nop;

    qps_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .advance (cycle_last),
        .load    (take_branch),
        .target  (br_target),
        .pc      (imem_addr)
    );

    qps_ir_stage #(.IW(IW), .NOP_WORD(NOP_WORD)) u_ir (
        .clk        (clk),
        .rst        (rst),
        .advance    (cycle_last),
        .flush      (take_branch),
        .fetch_word (imem_data),
        .instr      (exec_instr),
        .forced_nop (exec_nop)
    );

    assign rd_strobe = phase_strobe[RD_PHASE] && !exec_nop;
    assign wr_strobe = phase_strobe[WR_PHASE] && !exec_nop;

endmodule

// File: rtl/qps_sequencer_chk.sv
module qps_sequencer_chk #(
    parameter int            PC_W     = 13,
    parameter int            IW       = 14,
    parameter logic [IW-1:0] NOP_WORD = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            rc_mode,
    input logic [IW-1:0]   imem_data,
    input logic            br_req,
    input logic [PC_W-1:0] br_target,
    input logic [3:0]      phase_strobe,
    input logic            clkout,
    input logic [PC_W-1:0] imem_addr,
    input logic [IW-1:0]   exec_instr,
    input logic            exec_nop,
    input logic            rd_strobe,
    input logic            wr_strobe
);

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_strobe) == 1);

    assert_phase_rotate_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_strobe != 4'b0) |=>
            phase_strobe == {$past(phase_strobe[2:0]), $past(phase_strobe[3])});

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (phase_strobe == 4'b0001 && imem_addr == '0 &&
                 exec_instr == NOP_WORD && exec_nop));

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !phase_strobe[3] |=> $stable(imem_addr));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_strobe[3] && !(br_req && !exec_nop)) |=>
            imem_addr == $past(imem_addr) + 1'b1);

    assert_ir_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_strobe[3] && !(br_req && !exec_nop)) |=>
            (exec_instr == $past(imem_data) && !exec_nop));

    assert_ir_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !phase_strobe[3] |=> ($stable(exec_instr) && $stable(exec_nop)));

    assert_rd_phase_R5: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> (phase_strobe[1] && !exec_nop));

    assert_wr_phase_R5: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (phase_strobe[3] && !exec_nop));

    assert_branch_load_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_strobe[3] && br_req && !exec_nop) |=>
            (imem_addr == $past(br_target) && exec_nop && exec_instr == NOP_WORD));

    assert_nop_no_branch_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_strobe[3] && exec_nop) |=>
            (imem_addr == $past(imem_addr) + 1'b1 && !exec_nop));

    assert_clkout_R8: assert property (@(posedge clk) disable iff (rst)
        clkout == (rc_mode && (phase_strobe[0] || phase_strobe[1])));

endmodule

bind qps_sequencer qps_sequencer_chk #(
    .PC_W(PC_W), .IW(IW), .NOP_WORD(NOP_WORD)
) chk_i (.*);

// File: tb/qps_sequencer_tb_top.sv
module qps_sequencer_tb_top;

    localparam int PC_W = 13;
    localparam int IW   = 14;
    localparam logic [IW-1:0] NOP_W = '0;

    logic            clk = 1'b0;
    logic            rst;
    logic            rc_mode;
    logic [IW-1:0]   imem_data;
    logic            br_req;
    logic [PC_W-1:0] br_target;
    logic [3:0]      phase_strobe;
    logic            clkout;
    logic [PC_W-1:0] imem_addr;
    logic [IW-1:0]   exec_instr;
    logic            exec_nop;
    logic            rd_strobe;
    logic            wr_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    int              m_ph;
    logic [PC_W-1:0] m_pc;
    logic [IW-1:0]   m_ir;
    logic            m_nop;

    always #10 clk = ~clk;   // 50 MHz

    qps_sequencer #(.PC_W(PC_W), .IW(IW), .NOP_WORD(NOP_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .rc_mode      (rc_mode),
        .imem_data    (imem_data),
        .br_req       (br_req),
        .br_target    (br_target),
        .phase_strobe (phase_strobe),
        .clkout       (clkout),
        .imem_addr    (imem_addr),
        .exec_instr   (exec_instr),
        .exec_nop     (exec_nop),
        .rd_strobe    (rd_strobe),
        .wr_strobe    (wr_strobe)
    );

    function automatic logic [IW-1:0] mem_word(logic [PC_W-1:0] a);
        logic [31:0] w;
        w = 32'(a) * 32'd37 + 32'd11;
        return w[IW-1:0] ^ {1'b1, a};
    endfunction

    // program-memory stub
    assign imem_data = mem_word(imem_addr);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph  = 0;
        m_pc  = '0;
        m_ir  = NOP_W;
        m_nop = 1'b1;
    endtask

    task automatic check_all();
        chk("R1", "phase_strobe", 32'(phase_strobe), 32'(4'b0001 << m_ph));
        chk("R3", "imem_addr", 32'(imem_addr), 32'(m_pc));
        chk("R4", "exec_instr", 32'(exec_instr), 32'(m_ir));
        chk("R6", "exec_nop", 32'(exec_nop), 32'(m_nop));
        chk("R5", "rd_strobe", 32'(rd_strobe), 32'(m_ph == 1 && !m_nop));
        chk("R5", "wr_strobe", 32'(wr_strobe), 32'(m_ph == 3 && !m_nop));
        chk("R8", "clkout", 32'(clkout), 32'(rc_mode && m_ph < 2));
    endtask

    // drive at negedge, let one posedge pass, update model, check at next negedge
    task automatic step(bit r, bit br, logic [PC_W-1:0] tgt, bit rc);
        rst       = r;
        br_req    = br;
        br_target = tgt;
        rc_mode   = rc;
        @(posedge clk);
        if (r) begin
            model_reset();
        end else begin
            if (m_ph == 3) begin
                if (br && !m_nop) begin
                    m_pc  = tgt;
                    m_ir  = NOP_W;
                    m_nop = 1'b1;
                end else begin
                    m_ir  = mem_word(m_pc);
                    m_pc  = m_pc + 1'b1;
                    m_nop = 1'b0;
                end
            end
            m_ph = (m_ph + 1) % 4;
        end
        @(negedge clk);
        check_all();
    endtask

    // advance to the negedge inside the requested phase (0..3) without branching
    task automatic go_phase(int p, bit rc);
        while (m_ph != p) step(1'b0, 1'b0, '0, rc);
    endtask

    initial begin
        int unsigned seed;
        bit rc;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst = 1'b1; br_req = 1'b0; br_target = '0; rc_mode = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        // R2: reset state
        chk("R2", "phase after reset", 32'(phase_strobe), 32'h1);
        chk("R2", "addr after reset", 32'(imem_addr), 32'h0);
        chk("R2", "instr after reset", 32'(exec_instr), 32'(NOP_W));
        chk("R2", "nop after reset", 32'(exec_nop), 32'h1);
        rc = 1'b1;

        // R4: plain straight-line fetch for a few cycles
        repeat (16) step(1'b0, 1'b0, '0, rc);

        // R6 + R3: jump to last address, then wrap to zero
        go_phase(3, rc);
        step(1'b0, 1'b1, 13'h1FFF, rc);
        chk("R6", "branch target", 32'(imem_addr), 32'h1FFF);
        repeat (4) step(1'b0, 1'b0, '0, rc);
        chk("R6", "target executes", 32'(exec_instr), 32'(mem_word(13'h1FFF)));
        chk("R3", "wrap to zero", 32'(imem_addr), 32'h0);

        // R7: requests outside Q4 ignored
        go_phase(0, rc);
        step(1'b0, 1'b1, 13'h0AAA, rc);
        step(1'b0, 1'b1, 13'h0AAA, rc);
        step(1'b0, 1'b1, 13'h0AAA, rc);
        step(1'b0, 1'b0, '0, rc);
        chk("R7", "no branch outside Q4", 32'(imem_addr), 32'h1);

        // R7: held request, second Q4 falls in flushed slot
        go_phase(3, rc);
        step(1'b0, 1'b1, 13'h0100, rc);
        repeat (4) step(1'b0, 1'b1, 13'h0555, rc);
        chk("R7", "branch in nop slot ignored", 32'(imem_addr), 32'h0101);
        chk("R7", "nop slot ends", 32'(exec_nop), 32'h0);

        // R8: divided clock disabled
        repeat (4) step(1'b0, 1'b0, '0, 1'b0);
        rc = 1'b0;

        // R2: reset mid-run
        step(1'b1, 1'b0, '0, rc);
        step(1'b0, 1'b0, '0, rc);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit br;
            logic [PC_W-1:0] tgt;
            br  = ($urandom % 4) == 0;
            tgt = ($urandom % 8 == 0) ? PC_W'(13'h1FFC + ($urandom % 4))
                                      : PC_W'($urandom);
            if ($urandom % 10 == 0) rc = ~rc;
            step(($urandom % 500) == 0, br, tgt, rc);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule